// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block sits at the front of a floating-point datapath. It takes one raw register operand, up to four 32-bit words with word 0 the most significant, and a format selector. It expands the operand into a single wide internal form that later arithmetic stages can use without caring about the source format. The supported sources are a 32-bit two's-complement integer, single precision, double precision and a 128-bit extended precision.

The internal form has a sign, a signed unbiased exponent, a 128-bit mantissa whose unit bit sits at bit 123, a sticky bit and a class code. Denormal fractions and integers are left-normalized inside the block with a leading-zero count and a barrel shift. Signalling NaNs are quieted on entry, marked with their own class and flagged as invalid operations.

The unpack path is combinational and is registered once at the output. A result appears exactly one cycle after the operand is presented with `in_valid`.

Top module: `fp_operand_unpack`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. Each result carries the sign taken from bit 31 of word 0 for every format, with `out_sticky` cleared.
- R2: Format codes are 0 = integer, 1 = single, 2 = double, 3 = extended. Codes 4 to 7 set `out_fmt_err` and give class ZERO, mantissa 0, exponent 0 and `out_invalid` low.
- R3: Class codes are ZERO = 0, NUM = 1, INF = 2, QNAN = 3, SNAN = 4. A float with biased exponent 0 and an all-zero fraction gives ZERO with mantissa 0 and exponent 0.
- R4: A normal float gets exponent = biased exponent − bias (127, 1023 or 16383). Its mantissa has bit 123 set and the fraction placed directly below it, starting at bit 122.
- R5: A denormal float (biased exponent 0, nonzero fraction) has no implied one. It is normalized so that bit 123 is set, and its exponent is 1 − bias − shift.
- R6: A biased exponent of all ones with a zero fraction gives INF, with mantissa 0 and exponent 0.
- R7: A biased exponent of all ones with the top fraction bit (mantissa bit 122) set gives QNAN. The aligned fraction is copied through unchanged, the exponent is 0 and `out_invalid` is low.
- R8: A biased exponent of all ones with a nonzero fraction and bit 122 clear gives SNAN. Bit 122 is set in the output mantissa, and `out_invalid` is high.
- R9: The zero-fraction test spans every fraction bit in all input words. A double or extended NaN whose only set fraction bit is in its last word is classed as NaN, not INF.
- R10: An integer 0 gives ZERO. Any other integer is turned into its magnitude, negated when negative, and normalized to NUM with bit 123 set and exponent equal to the magnitude's top set bit position.
- R11: `out_invalid` is high for SNAN results and for no other result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_fmt | input | 3 | Format selector |
| in_w0 | input | 32 | Operand word 0 (sign and exponent, most significant) |
| in_w1 | input | 32 | Operand word 1 |
| in_w2 | input | 32 | Operand word 2 |
| in_w3 | input | 32 | Operand word 3 (least significant) |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Sign |
| out_exp | output | EXP_W (20) | Signed unbiased exponent |
| out_mant | output | MANT_W (128) | Mantissa, unit bit at UNIT_POS (123) |
| out_sticky | output | 1 | Sticky bit, always cleared |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Invalid-operation flag |
| out_fmt_err | output | 1 | Unsupported format code |

## Verification
The block keeps no state from one operand to the next, apart from the held output register. A fault in the leading-zero count or shift shows up in the result of the same operand, one cycle after it is presented. It appears as a mantissa without bit 123 set or as an exponent that is off by the shift error. A fault in the class decode shows as a wrong class code or invalid flag in that same cycle. The scoreboard compares every field of every result against an independent model. It also checks that no result appears for an idle cycle, so a stuck or misaligned valid bit is caught at the first mismatch.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

    // Class codes seen at out_class
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_class_e;

    // Format selector codes
    localparam logic [2:0] FMT_INT = 3'd0;
    localparam logic [2:0] FMT_SGL = 3'd1;
    localparam logic [2:0] FMT_DBL = 3'd2;
    localparam logic [2:0] FMT_EXT = 3'd3;

    // Field sizes of the memory formats
    localparam int SGL_EB = 8;
    localparam int SGL_FB = 23;
    localparam int DBL_EB = 11;
    localparam int DBL_FB = 52;
    localparam int EXT_EB = 15;
    localparam int EXT_FB = 112;

endpackage

// File: rtl/fpu_field_split.sv
module fpu_field_split
    import fpu_unpack_pkg::*;
#(
    parameter int MANT_W   = 128,
    parameter int UNIT_POS = 123,
    parameter int BEXP_W   = 15
) (
    input  logic [2:0]        fmt,
    input  logic [31:0]       w0,
    input  logic [31:0]       w1,
    input  logic [31:0]       w2,
    input  logic [31:0]       w3,
    output logic              fmt_ok,
    output logic              is_int,
    output logic [BEXP_W-1:0] bexp,
    output logic [BEXP_W-1:0] bexp_max,
    output logic [BEXP_W-1:0] bias,
    output logic [MANT_W-1:0] frac_al,
    output logic [31:0]       int_mag
);

    // Left shift that puts the top fraction bit just below the unit bit
    localparam int SGL_SH = UNIT_POS - SGL_FB;
    localparam int DBL_SH = UNIT_POS - DBL_FB;
    localparam int EXT_SH = UNIT_POS - EXT_FB;

    localparam logic [BEXP_W-1:0] SGL_MAX  = BEXP_W'((1 << SGL_EB) - 1);
    localparam logic [BEXP_W-1:0] DBL_MAX  = BEXP_W'((1 << DBL_EB) - 1);
    localparam logic [BEXP_W-1:0] EXT_MAX  = BEXP_W'((1 << EXT_EB) - 1);
    localparam logic [BEXP_W-1:0] SGL_BIAS = BEXP_W'((1 << (SGL_EB - 1)) - 1);
    localparam logic [BEXP_W-1:0] DBL_BIAS = BEXP_W'((1 << (DBL_EB - 1)) - 1);
    localparam logic [BEXP_W-1:0] EXT_BIAS = BEXP_W'((1 << (EXT_EB - 1)) - 1);

    logic [SGL_FB-1:0] sgl_frac;
    logic [DBL_FB-1:0] dbl_frac;
    logic [EXT_FB-1:0] ext_frac;

    always_comb begin
        sgl_frac = w0[SGL_FB-1:0];
        dbl_frac = {w0[DBL_FB-33:0], w1};
        ext_frac = {w0[EXT_FB-97:0], w1, w2, w3};
        int_mag  = w0[31] ? (~w0 + 32'd1) : w0;

        fmt_ok   = 1'b1;
        is_int   = 1'b0;
        bexp     = '0;
        bexp_max = '1;
        bias     = '0;
        frac_al  = '0;

        unique case (fmt)
            FMT_INT: begin
                is_int = 1'b1;
            end
            FMT_SGL: begin
                bexp     = BEXP_W'(w0[30 -: SGL_EB]);
                bexp_max = SGL_MAX;
                bias     = SGL_BIAS;
                frac_al  = MANT_W'(sgl_frac) << SGL_SH;
            end
            FMT_DBL: begin
                bexp     = BEXP_W'(w0[30 -: DBL_EB]);
                bexp_max = DBL_MAX;
                bias     = DBL_BIAS;
                frac_al  = MANT_W'(dbl_frac) << DBL_SH;
            end
            FMT_EXT: begin
                bexp     = BEXP_W'(w0[30 -: EXT_EB]);
                bexp_max = EXT_MAX;
                bias     = EXT_BIAS;
                frac_al  = MANT_W'(ext_frac) << EXT_SH;
            end
            default: begin
                fmt_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fpu_lead_norm.sv
module fpu_lead_norm #(
    parameter int MANT_W   = 128,
    parameter int UNIT_POS = 123,
    parameter int EXP_W    = 20
) (
    input  logic [MANT_W-1:0]        mant_in,
    input  logic signed [EXP_W-1:0]  exp_in,
    output logic [MANT_W-1:0]        mant_out,
    output logic signed [EXP_W-1:0]  exp_out
);

    localparam int SH_W = $clog2(UNIT_POS + 1);

    logic [SH_W-1:0]         msb_pos;
    logic [SH_W-1:0]         shift_amt;
    logic signed [EXP_W-1:0] shift_s;

    // Priority encoder over the bits at or below the unit position:
    // the highest set bit wins.
    always_comb begin
        msb_pos = '0;
        for (int i = 0; i <= UNIT_POS; i++) begin
            if (mant_in[i]) begin
                msb_pos = SH_W'(i);
            end
        end
    end

    always_comb begin
        shift_amt = SH_W'(UNIT_POS) - msb_pos;
        shift_s   = EXP_W'(shift_amt);
        mant_out  = mant_in << shift_amt;
        exp_out   = exp_in - shift_s;
    end

endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
    import fpu_unpack_pkg::*;
#(
    parameter int MANT_W   = 128,
    parameter int UNIT_POS = 123,
    parameter int EXP_W    = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               in_fmt,
    input  logic [31:0]              in_w0,
    input  logic [31:0]              in_w1,
    input  logic [31:0]              in_w2,
    input  logic [31:0]              in_w3,
    output logic                     out_valid,
    output logic                     out_sign,
    output logic signed [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0]        out_mant,
    output logic                     out_sticky,
    output logic [2:0]               out_class,
    output logic                     out_invalid,
    output logic                     out_fmt_err
);

    localparam int BEXP_W  = EXT_EB;
    localparam int QUIET_POS = UNIT_POS - 1;
    localparam logic [MANT_W-1:0] UNIT_ONE  = MANT_W'(1) << UNIT_POS;
    localparam logic [MANT_W-1:0] QUIET_ONE = MANT_W'(1) << QUIET_POS;

    typedef struct packed {
        logic                    valid;
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
        logic                    sticky;
        logic [2:0]              cls;
        logic                    invalid;
        logic                    fmt_err;
    } stage_t;

    // Field extraction
    logic              fmt_ok;
    logic              is_int;
    logic [BEXP_W-1:0] bexp;
    logic [BEXP_W-1:0] bexp_max;
    logic [BEXP_W-1:0] bias;
    logic [MANT_W-1:0] frac_al;
    logic [31:0]       int_mag;

    fpu_field_split #(
        .MANT_W   (MANT_W),
        .UNIT_POS (UNIT_POS),
        .BEXP_W   (BEXP_W)
    ) u_split (
        .fmt      (in_fmt),
        .w0       (in_w0),
        .w1       (in_w1),
        .w2       (in_w2),
        .w3       (in_w3),
        .fmt_ok   (fmt_ok),
        .is_int   (is_int),
        .bexp     (bexp),
        .bexp_max (bexp_max),
        .bias     (bias),
        .frac_al  (frac_al),
        .int_mag  (int_mag)
    );

    // Normalizer source: integer magnitude or denormal fraction
    logic signed [EXP_W-1:0] bexp_s;
    logic signed [EXP_W-1:0] bias_s;
    logic [MANT_W-1:0]       norm_src_mant;
    logic signed [EXP_W-1:0] norm_src_exp;
    logic [MANT_W-1:0]       norm_mant;
    logic signed [EXP_W-1:0] norm_exp;

    always_comb begin
        bexp_s        = EXP_W'(bexp);
        bias_s        = EXP_W'(bias);
        norm_src_mant = is_int ? MANT_W'(int_mag) : frac_al;
        norm_src_exp  = is_int ? EXP_W'(UNIT_POS) : (EXP_W'(1) - bias_s);
    end

    fpu_lead_norm #(
        .MANT_W   (MANT_W),
        .UNIT_POS (UNIT_POS),
        .EXP_W    (EXP_W)
    ) u_norm (
        .mant_in  (norm_src_mant),
        .exp_in   (norm_src_exp),
        .mant_out (norm_mant),
        .exp_out  (norm_exp)
    );

    // Classification and next-state selection
    stage_t res;
    stage_t st_d;
    stage_t st_q;
    logic   frac_nz;

    always_comb begin
        frac_nz     = |frac_al;
        res         = '0;
        res.valid   = 1'b1;
        res.sign    = in_w0[31];
        res.sticky  = 1'b0;
        res.cls     = CLS_ZERO;

        if (!fmt_ok) begin
            res.fmt_err = 1'b1;
        end else if (is_int) begin
            if (int_mag != 32'd0) begin
                res.cls  = CLS_NUM;
                res.mant = norm_mant;
                res.exp  = norm_exp;
            end
        end else if (bexp == '0) begin
            if (frac_nz) begin
                res.cls  = CLS_NUM;
                res.mant = norm_mant;
                res.exp  = norm_exp;
            end
        end else if (bexp == bexp_max) begin
            if (!frac_nz) begin
                res.cls = CLS_INF;
            end else if (frac_al[QUIET_POS]) begin
                res.cls  = CLS_QNAN;
                res.mant = frac_al;
            end else begin
                res.cls     = CLS_SNAN;
                res.mant    = frac_al | QUIET_ONE;
                res.invalid = 1'b1;
            end
        end else begin
            res.cls  = CLS_NUM;
            res.mant = frac_al | UNIT_ONE;
            res.exp  = bexp_s - bias_s;
        end

        st_d       = in_valid ? res : st_q;
        st_d.valid = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_sign    = st_q.sign;
    assign out_exp     = st_q.exp;
    assign out_mant    = st_q.mant;
    assign out_sticky  = st_q.sticky;
    assign out_class   = st_q.cls;
    assign out_invalid = st_q.invalid;
    assign out_fmt_err = st_q.fmt_err;

    // Checks on the registered result
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sign == $past(in_w0[31])));

    assert_fmt_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt_err) |-> (out_class == CLS_ZERO && !out_invalid && out_mant == '0));

    assert_empty_mant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_class == CLS_ZERO || out_class == CLS_INF)) |-> (out_mant == '0));

    assert_unit_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_NUM) |-> (out_mant[UNIT_POS] && out_mant[MANT_W-1:UNIT_POS+1] == '0));

    assert_snan_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_SNAN) |-> out_mant[QUIET_POS]);

    assert_invalid_only_snan_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_invalid == (out_class == CLS_SNAN)));

endmodule

// File: tb/sim_fp_operand_unpack.sv
module sim_fp_operand_unpack;

    localparam int MANT_W = 128;
    localparam int UNIT   = 123;
    localparam int EXP_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [2:0]        in_fmt = '0;
    logic [31:0]       in_w0 = '0;
    logic [31:0]       in_w1 = '0;
    logic [31:0]       in_w2 = '0;
    logic [31:0]       in_w3 = '0;
    logic              out_valid;
    logic              out_sign;
    logic signed [EXP_W-1:0] out_exp;
    logic [MANT_W-1:0] out_mant;
    logic              out_sticky;
    logic [2:0]        out_class;
    logic              out_invalid;
    logic              out_fmt_err;

    always #2 clk = ~clk;

    fp_operand_unpack u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_fmt      (in_fmt),
        .in_w0       (in_w0),
        .in_w1       (in_w1),
        .in_w2       (in_w2),
        .in_w3       (in_w3),
        .out_valid   (out_valid),
        .out_sign    (out_sign),
        .out_exp     (out_exp),
        .out_mant    (out_mant),
        .out_sticky  (out_sticky),
        .out_class   (out_class),
        .out_invalid (out_invalid),
        .out_fmt_err (out_fmt_err)
    );

    typedef struct {
        logic              sign;
        int                exp;
        logic [MANT_W-1:0] mant;
        logic [2:0]        cls;
        logic              inv;
        logic              err;
        string             tag;
    } exp_item_t;

    exp_item_t sbq[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Independent expectation built from the requirement text
    function automatic exp_item_t model(input logic [2:0] f, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] c,
                                        input logic [31:0] d);
        exp_item_t r;
        logic [MANT_W-1:0] fr;
        logic [31:0] mag;
        int e, emax, bias, p;
        bit isf;
        r.sign = a[31]; r.exp = 0; r.mant = '0; r.cls = 3'd0; r.inv = 1'b0; r.err = 1'b0;
        r.tag = "";
        isf = 1'b1; e = 0; emax = 0; bias = 0; fr = '0;
        case (f)
            3'd0: begin
                isf = 1'b0;
                mag = a[31] ? (~a + 32'd1) : a;
                if (mag != 0) begin
                    p = 0;
                    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
                    r.cls = 3'd1; r.exp = p; r.mant = MANT_W'(mag) << (UNIT - p);
                end
            end
            3'd1: begin e = int'(a[30:23]); emax = 255;   bias = 127;   fr = MANT_W'(a[22:0]) << 100; end
            3'd2: begin e = int'(a[30:20]); emax = 2047;  bias = 1023;  fr = MANT_W'({a[19:0], b}) << 71; end
            3'd3: begin e = int'(a[30:16]); emax = 32767; bias = 16383; fr = MANT_W'({a[15:0], b, c, d}) << 11; end
            default: begin isf = 1'b0; r.err = 1'b1; end
        endcase
        if (isf) begin
            if (e == 0) begin
                if (fr != 0) begin
                    p = 0;
                    for (int i = 0; i < MANT_W; i++) if (fr[i]) p = i;
                    r.cls = 3'd1; r.mant = fr << (UNIT - p); r.exp = 1 - bias - (UNIT - p);
                end
            end else if (e == emax) begin
                if (fr == 0) r.cls = 3'd2;
                else if (fr[UNIT-1]) begin r.cls = 3'd3; r.mant = fr; end
                else begin r.cls = 3'd4; r.mant = fr; r.mant[UNIT-1] = 1'b1; r.inv = 1'b1; end
            end else begin
                r.cls = 3'd1; r.mant = fr; r.mant[UNIT] = 1'b1; r.exp = e - bias;
            end
        end
        return r;
    endfunction

    task automatic send(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [31:0] d, input string tag);
        exp_item_t e;
        e = model(f, a, b, c, d);
        e.tag = tag;
        @(negedge clk);
        in_valid = 1'b1; in_fmt = f; in_w0 = a; in_w1 = b; in_w2 = c; in_w3 = d;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_w0 = 32'hA5A5_5A5A;
        end
    endtask

    // Monitor: pops one expectation per result
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL R1: result with no pending operand, actual out_valid=1 expected 0");
            end else begin
                exp_item_t e;
                e = sbq.pop_front();
                if (out_sign !== e.sign || int'(out_exp) != e.exp || out_mant !== e.mant ||
                    out_class !== e.cls || out_invalid !== e.inv || out_fmt_err !== e.err ||
                    out_sticky !== 1'b0) begin
                    fails++;
                    $display("FAIL %s: actual s=%0d e=%0d m=%h c=%0d inv=%0d err=%0d stk=%0d expected s=%0d e=%0d m=%h c=%0d inv=%0d err=%0d stk=0",
                             e.tag, out_sign, int'(out_exp), out_mant, out_class, out_invalid,
                             out_fmt_err, out_sticky, e.sign, e.exp, e.mant, e.cls, e.inv, e.err);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_class !== 3'd0 || out_mant !== '0) begin
            fails++;
            $display("FAIL R1: reset state actual v=%0d c=%0d expected v=0 c=0", out_valid, out_class);
        end
        rst_n = 1'b1;
        idle(2);

        // Single precision
        send(3'd1, 32'h3F80_0000, 0, 0, 0, "R4 single 1.0");
        send(3'd1, 32'hC020_0000, 0, 0, 0, "R4 single -2.5");
        send(3'd1, 32'h0000_0000, 0, 0, 0, "R3 single +0");
        send(3'd1, 32'h8000_0000, 0, 0, 0, "R3 single -0 sign");
        send(3'd1, 32'h0000_0001, 0, 0, 0, "R5 single min denormal");
        send(3'd1, 32'h807F_FFFF, 0, 0, 0, "R5 single max denormal");
        send(3'd1, 32'h7F80_0000, 0, 0, 0, "R6 single +inf");
        send(3'd1, 32'hFF80_0000, 0, 0, 0, "R6 single -inf");
        send(3'd1, 32'h7FC0_0001, 0, 0, 0, "R7 single qnan");
        send(3'd1, 32'hFF80_0001, 0, 0, 0, "R8 single snan");
        idle(2);
        // Double precision
        send(3'd2, 32'h3FF0_0000, 32'h0, 0, 0, "R4 double 1.0");
        send(3'd2, 32'hC00C_0000, 32'h1, 0, 0, "R4 double -3.5 plus lsb");
        send(3'd2, 32'h0000_0000, 32'h1, 0, 0, "R5 double min denormal");
        send(3'd2, 32'h7FF0_0000, 32'h0, 0, 0, "R6 double inf");
        send(3'd2, 32'h7FF0_0000, 32'h1, 0, 0, "R9 double nan lsb only");
        send(3'd2, 32'h7FF8_0000, 32'h0, 0, 0, "R7 double qnan");
        // Extended precision
        send(3'd3, 32'h3FFF_0000, 0, 0, 0, "R4 extended 1.0");
        send(3'd3, 32'h4000_8000, 0, 0, 32'h1, "R4 extended 3.0 plus lsb");
        send(3'd3, 32'h0000_0000, 0, 0, 32'h1, "R5 extended min denormal");
        send(3'd3, 32'h7FFF_0000, 0, 0, 32'h1, "R9 extended nan last word");
        send(3'd3, 32'hFFFF_8000, 0, 32'h10, 0, "R7 extended qnan");
        send(3'd3, 32'h7FFF_0000, 0, 0, 0, "R6 extended inf");
        idle(1);
        // Integers
        send(3'd0, 32'h0000_0000, 0, 0, 0, "R10 int zero");
        send(3'd0, 32'h0000_0001, 0, 0, 0, "R10 int one");
        send(3'd0, 32'hFFFF_FFFF, 0, 0, 0, "R10 int minus one");
        send(3'd0, 32'h8000_0000, 0, 0, 0, "R10 int most negative");
        send(3'd0, 32'h7FFF_FFFF, 0, 0, 0, "R10 int most positive");
        send(3'd0, 32'h0000_3039, 0, 0, 0, "R10 int 12345");
        // Unsupported formats
        send(3'd5, 32'h7F80_0001, 32'hFFFF_FFFF, 0, 0, "R2 format 5");
        send(3'd7, 32'hFFFF_FFFF, 32'h1, 32'h2, 32'h3, "R2 format 7");
        // Invalid flag only on signalling input among mixed stream
        send(3'd2, 32'h7FF4_0000, 32'h0, 0, 0, "R11 double snan");
        send(3'd3, 32'h7FFF_4000, 0, 0, 0, "R11 extended snan");
        send(3'd1, 32'h7FFF_FFFF, 0, 0, 0, "R11 single qnan no flag");
        idle(4);

        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R1: pending results actual %0d expected 0", sbq.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1: watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule